// File: doc/BRIEF.md
# Voice-activity power sequencer

This block decides when a multi-channel audio ADC is powered and when the host is told about speech. A voice-activity detector outside the block reports, for each of four channels, single-cycle "voice present" and "voice gone" events. The sequencer watches one programmable channel and ignores the other three. On a qualifying voice event it latches an interrupt level, which stays high until the host acknowledges it.

A two-bit policy code decides who may switch the ADC on and who may switch it off. Each direction is assigned either to the detector's events or to host request pulses. A recording-detect enable decides whether detector events still count while the ADC is powered. A pin-sharing enable lets the serial data output carry the interrupt level while the ADC is off. While the ADC records, that pin always carries audio.

Configuration lives in two byte-wide registers written through a synchronous address/data/write-enable port. The detector clock source and the external frequency codes are stored there and passed straight out to the clock logic.

Top module: `vad_power_sequencer`

## Requirements
- R1: On a synchronous reset the policy code becomes 0, the channel select becomes 2, the clock source and frequency codes become 0, recording-detect becomes 1 and pin sharing becomes 0. The ADC is off and the interrupt is low from the first cycle after reset.
- R2: Register address 0 holds the policy code in bits 7:6, the channel select in bits 5:4, the clock source code in bits 3:2 and the external frequency code in bits 1:0. Register address 1 holds recording-detect in bit 0 and pin sharing in bit 1; its other bits are ignored. A write takes effect at the clock edge where the write enable is sampled.
- R3: Only events on lane `chan_sel` of `voice_det`/`voice_lost` count. Select value n watches lane n, which is channel n+1. Events on the other lanes change neither the power state nor the interrupt.
- R4: With policy 0, only `host_pwr_up` turns the ADC on and only `host_pwr_down` turns it off. Detector events never change the power state.
- R5: With policy 1, a qualifying voice event turns the ADC on and a qualifying voice-gone event turns it off. Host power requests are ignored.
- R6: With policy 2, a qualifying voice event turns the ADC on and only `host_pwr_down` turns it off. `host_pwr_up` and voice-gone events are ignored.
- R7: With policy 3, only `host_pwr_up` turns the ADC on and a qualifying voice-gone event turns it off. Voice events and `host_pwr_down` do not change the power state.
- R8: A qualifying voice event sets `irq` one clock later under every policy. `irq` then stays high.
- R9: `irq_ack` clears `irq` one clock later. When an acknowledge and a voice event arrive together, the acknowledge wins. A voice event in the following cycle sets `irq` again.
- R10: While the ADC is on and recording-detect is 0, voice and voice-gone events are ignored: no interrupt and no automatic power change. While the ADC is off, events always qualify.
- R11: `sdout` equals `irq` while pin sharing is 1 and the ADC is off. Otherwise `sdout` equals `adc_audio_sd`.
- R12: `vad_clk_src` and `vad_ext_freq` always show the stored clock source and frequency codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | CFG_ADDR_W | Configuration register address |
| cfg_wdata | input | CFG_DATA_W | Configuration write data |
| voice_det | input | NUM_CH | Per-channel voice-present event pulses |
| voice_lost | input | NUM_CH | Per-channel voice-gone event pulses |
| host_pwr_up | input | 1 | Host request pulse to power the ADC on |
| host_pwr_down | input | 1 | Host request pulse to power the ADC off |
| irq_ack | input | 1 | Host interrupt acknowledge pulse |
| adc_audio_sd | input | 1 | Serial audio data from the ADC datapath |
| adc_power_on | output | 1 | ADC power enable, high while recording |
| irq | output | 1 | Latched voice interrupt level |
| sdout | output | 1 | Shared serial data output pin |
| vad_clk_src | output | 2 | Stored detector clock source code |
| vad_ext_freq | output | 2 | Stored external clock frequency code |

## Verification
The bound checker checks several rules on every cycle: reset clearing, that the interrupt only rises after a qualifying voice event, acknowledge clearing, and the policy rules that block automatic power-up or hold power against host requests. It also checks the suppression of interrupts while recording with detection disabled, and that the pin carries audio while recording. The register bit packing, the channel mapping, which host pulse each policy honours, and the acknowledge-versus-event ordering need whole scenarios. The bench shows these by comparing every cycle against its own model under directed sequences and a long random stream with occasional reconfiguration.

// File: rtl/vadps_pkg.sv
package vadps_pkg;

   localparam int CH_SEL_W   = 2;
   localparam int CLK_CODE_W = 2;

   typedef enum logic [1:0] {
      POL_HOST_BOTH = 2'd0,
      POL_AUTO_BOTH = 2'd1,
      POL_AUTO_UP   = 2'd2,
      POL_AUTO_DOWN = 2'd3
   } pwr_policy_e;

   typedef enum logic {
      PWR_OFF = 1'b0,
      PWR_ON  = 1'b1
   } pwr_state_e;

   typedef struct packed {
      pwr_policy_e             policy;
      logic [CH_SEL_W-1:0]     chan_sel;
      logic [CLK_CODE_W-1:0]   clk_src;
      logic [CLK_CODE_W-1:0]   ext_freq;
      logic                    rec_det_en;
      logic                    pin_share_en;
   } cfg_t;

   function automatic logic policy_auto_up(input pwr_policy_e p);
      return (p == POL_AUTO_BOTH) || (p == POL_AUTO_UP);
   endfunction

   function automatic logic policy_auto_down(input pwr_policy_e p);
      return (p == POL_AUTO_BOTH) || (p == POL_AUTO_DOWN);
   endfunction

endpackage

// File: rtl/vadps_cfg_regs.sv
module vadps_cfg_regs
   import vadps_pkg::*;
#(
   parameter int          ADDR_W       = 1,
   parameter int          DATA_W       = 8,
   parameter logic [1:0]  POLICY_RST   = 2'd0,
   parameter logic [1:0]  CHAN_RST     = 2'd2,
   parameter logic [1:0]  CLK_SRC_RST  = 2'd0,
   parameter logic [1:0]  EXT_FREQ_RST = 2'd0,
   parameter logic        REC_DET_RST  = 1'b1,
   parameter logic        PIN_SHR_RST  = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output cfg_t              cfg
);

   localparam logic [ADDR_W-1:0] ADDR_SEL  = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] ADDR_DET  = ADDR_W'(1);
   localparam int POL_LSB   = 6;
   localparam int CHAN_LSB  = 4;
   localparam int CLK_LSB   = 2;
   localparam int FREQ_LSB  = 0;
   localparam int REC_BIT   = 0;
   localparam int SHR_BIT   = 1;

   localparam cfg_t CFG_RST = '{
      policy:       pwr_policy_e'(POLICY_RST),
      chan_sel:     CHAN_RST,
      clk_src:      CLK_SRC_RST,
      ext_freq:     EXT_FREQ_RST,
      rec_det_en:   REC_DET_RST,
      pin_share_en: PIN_SHR_RST
   };

   if (DATA_W < 8) begin : g_bad_width
      $error("vadps_cfg_regs: DATA_W must be at least 8");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("vadps_cfg_regs: ADDR_W must be at least 1");
   end

   cfg_t cfg_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_q <= CFG_RST;
      end else if (we) begin
         if (addr == ADDR_SEL) begin
            cfg_q.policy   <= pwr_policy_e'(wdata[POL_LSB +: 2]);
            cfg_q.chan_sel <= wdata[CHAN_LSB +: CH_SEL_W];
            cfg_q.clk_src  <= wdata[CLK_LSB +: CLK_CODE_W];
            cfg_q.ext_freq <= wdata[FREQ_LSB +: CLK_CODE_W];
         end else if (addr == ADDR_DET) begin
            cfg_q.rec_det_en   <= wdata[REC_BIT];
            cfg_q.pin_share_en <= wdata[SHR_BIT];
         end
      end
   end

   assign cfg = cfg_q;

endmodule

// File: rtl/vadps_event_sel.sv
module vadps_event_sel
   import vadps_pkg::*;
#(
   parameter int NUM_CH = 4
) (
   input  logic [NUM_CH-1:0]   voice_det,
   input  logic [NUM_CH-1:0]   voice_lost,
   input  logic [CH_SEL_W-1:0] chan_sel,
   input  logic                adc_on,
   input  logic                rec_det_en,
   output logic                voice_q,
   output logic                lost_q
);

   logic [NUM_CH-1:0] lane_mask;
   logic              det_live;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
      assign lane_mask[g] = (chan_sel == CH_SEL_W'(g));
   end

   assign det_live = !adc_on || rec_det_en;
   assign voice_q  = det_live && |(voice_det  & lane_mask);
   assign lost_q   = det_live && |(voice_lost & lane_mask);

endmodule

// File: rtl/vadps_power_fsm.sv
module vadps_power_fsm
   import vadps_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  pwr_policy_e policy,
   input  logic        voice_q,
   input  logic        lost_q,
   input  logic        host_up,
   input  logic        host_down,
   output logic        adc_on
);

   pwr_state_e state_q, state_d;
   logic       go_up, go_down;

   always_comb begin
      go_up   = policy_auto_up(policy)   ? voice_q : host_up;
      go_down = policy_auto_down(policy) ? lost_q  : host_down;
      state_d = state_q;
      unique case (state_q)
         PWR_OFF: if (go_up)   state_d = PWR_ON;
         PWR_ON:  if (go_down) state_d = PWR_OFF;
         default: state_d = PWR_OFF;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= PWR_OFF;
      else     state_q <= state_d;
   end

   assign adc_on = (state_q == PWR_ON);

endmodule

// File: rtl/vadps_irq_out.sv
module vadps_irq_out (
   input  logic clk,
   input  logic rst,
   input  logic voice_q,
   input  logic ack,
   input  logic adc_on,
   input  logic pin_share_en,
   input  logic audio_sd,
   output logic irq,
   output logic sdout
);

   logic irq_q;

   always_ff @(posedge clk) begin
      if (rst)          irq_q <= 1'b0;
      else if (ack)     irq_q <= 1'b0;
      else if (voice_q) irq_q <= 1'b1;
   end

   assign irq   = irq_q;
   assign sdout = (pin_share_en && !adc_on) ? irq_q : audio_sd;

endmodule

// File: rtl/vad_power_sequencer.sv
module vad_power_sequencer
   import vadps_pkg::*;
#(
   parameter int NUM_CH     = 4,
   parameter int CFG_ADDR_W = 1,
   parameter int CFG_DATA_W = 8
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  cfg_we,
   input  logic [CFG_ADDR_W-1:0] cfg_addr,
   input  logic [CFG_DATA_W-1:0] cfg_wdata,
   input  logic [NUM_CH-1:0]     voice_det,
   input  logic [NUM_CH-1:0]     voice_lost,
   input  logic                  host_pwr_up,
   input  logic                  host_pwr_down,
   input  logic                  irq_ack,
   input  logic                  adc_audio_sd,
   output logic                  adc_power_on,
   output logic                  irq,
   output logic                  sdout,
   output logic [1:0]            vad_clk_src,
   output logic [1:0]            vad_ext_freq
);

   localparam int LANES = 1 << CH_SEL_W;

   if (NUM_CH != LANES) begin : g_bad_ch
      $error("vad_power_sequencer: NUM_CH must equal 2**CH_SEL_W");
   end

   cfg_t cfg_q;
   logic voice_q;
   logic lost_q;
   logic adc_on;

   vadps_cfg_regs #(
      .ADDR_W (CFG_ADDR_W),
      .DATA_W (CFG_DATA_W)
   ) u_cfg (
      .clk   (clk),
      .rst   (rst),
      .we    (cfg_we),
      .addr  (cfg_addr),
      .wdata (cfg_wdata),
      .cfg   (cfg_q)
   );

   vadps_event_sel #(
      .NUM_CH (NUM_CH)
   ) u_evt (
      .voice_det  (voice_det),
      .voice_lost (voice_lost),
      .chan_sel   (cfg_q.chan_sel),
      .adc_on     (adc_on),
      .rec_det_en (cfg_q.rec_det_en),
      .voice_q    (voice_q),
      .lost_q     (lost_q)
   );

   vadps_power_fsm u_pwr (
      .clk       (clk),
      .rst       (rst),
      .policy    (cfg_q.policy),
      .voice_q   (voice_q),
      .lost_q    (lost_q),
      .host_up   (host_pwr_up),
      .host_down (host_pwr_down),
      .adc_on    (adc_on)
   );

   vadps_irq_out u_irq (
      .clk          (clk),
      .rst          (rst),
      .voice_q      (voice_q),
      .ack          (irq_ack),
      .adc_on       (adc_on),
      .pin_share_en (cfg_q.pin_share_en),
      .audio_sd     (adc_audio_sd),
      .irq          (irq),
      .sdout        (sdout)
   );

   assign adc_power_on = adc_on;
   assign vad_clk_src  = cfg_q.clk_src;
   assign vad_ext_freq = cfg_q.ext_freq;

endmodule

// File: rtl/vadps_checker.sv
module vadps_checker (
   input logic       clk,
   input logic       rst,
   input logic       adc_power_on,
   input logic       irq,
   input logic       irq_ack,
   input logic       host_pwr_up,
   input logic       sdout,
   input logic       adc_audio_sd,
   input logic [1:0] policy,
   input logic       rec_det_en,
   input logic       voice_q,
   input logic       lost_q
);

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (!adc_power_on && !irq)); // R1

   AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
      $rose(irq) |-> $past(voice_q)); // R8

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
      irq_ack |=> !irq); // R9

   AST_NO_AUTO_UP: assert property (@(posedge clk) disable iff (rst)
      (!adc_power_on && !host_pwr_up && (policy == 2'd0 || policy == 2'd3))
      |=> !adc_power_on); // R4

   AST_HOLD_ON_AUTO_DOWN: assert property (@(posedge clk) disable iff (rst)
      (adc_power_on && !lost_q && (policy == 2'd1 || policy == 2'd3))
      |=> adc_power_on); // R5

   AST_REC_SUPPRESS: assert property (@(posedge clk) disable iff (rst)
      (adc_power_on && !rec_det_en && !irq) |=> !irq); // R10

   AST_SDOUT_RECORDING: assert property (@(posedge clk) disable iff (rst)
      adc_power_on |-> (sdout == adc_audio_sd)); // R11

endmodule

bind vad_power_sequencer vadps_checker u_chk (
   .clk          (clk),
   .rst          (rst),
   .adc_power_on (adc_power_on),
   .irq          (irq),
   .irq_ack      (irq_ack),
   .host_pwr_up  (host_pwr_up),
   .sdout        (sdout),
   .adc_audio_sd (adc_audio_sd),
   .policy       (cfg_q.policy),
   .rec_det_en   (cfg_q.rec_det_en),
   .voice_q      (voice_q),
   .lost_q       (lost_q)
);

// File: tb/tb_vad_power_sequencer.sv
`timescale 1ns/1ps
module tb_vad_power_sequencer;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cfg_we = 1'b0;
   logic [0:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic [3:0] voice_det = '0;
   logic [3:0] voice_lost = '0;
   logic       host_pwr_up = 1'b0;
   logic       host_pwr_down = 1'b0;
   logic       irq_ack = 1'b0;
   logic       adc_audio_sd = 1'b0;
   logic       adc_power_on, irq, sdout;
   logic [1:0] vad_clk_src, vad_ext_freq;

   always #2 clk = ~clk;

   vad_power_sequencer dut (
      .clk (clk), .rst (rst), .cfg_we (cfg_we), .cfg_addr (cfg_addr),
      .cfg_wdata (cfg_wdata), .voice_det (voice_det), .voice_lost (voice_lost),
      .host_pwr_up (host_pwr_up), .host_pwr_down (host_pwr_down),
      .irq_ack (irq_ack), .adc_audio_sd (adc_audio_sd),
      .adc_power_on (adc_power_on), .irq (irq), .sdout (sdout),
      .vad_clk_src (vad_clk_src), .vad_ext_freq (vad_ext_freq)
   );

   typedef struct packed {
      logic       on;
      logic       irq;
      logic       sd;
      logic [1:0] cs;
      logic [1:0] ef;
   } exp_t;

   exp_t  exp_q[$];
   string req_q[$];
   int    n_vec  = 0;
   int    n_miss = 0;
   bit    done   = 0;

   // model state, derived from the requirements
   logic       m_on, m_irq, m_rec, m_shr;
   logic [1:0] m_pol, m_ch, m_cs, m_ef;

   task automatic step(input logic r, input logic we, input logic ad,
                       input logic [7:0] wd, input logic [3:0] vd,
                       input logic [3:0] vl, input logic hu, input logic hd,
                       input logic ak, input logic au, input string req);
      logic vq, lq, aup, adn, n_on, n_irq;
      exp_t e;
      @(negedge clk);
      rst = r; cfg_we = we; cfg_addr = ad; cfg_wdata = wd;
      voice_det = vd; voice_lost = vl; host_pwr_up = hu;
      host_pwr_down = hd; irq_ack = ak; adc_audio_sd = au;
      if (r) begin
         m_on = 0; m_irq = 0; m_pol = 2'd0; m_ch = 2'd2; m_cs = 0;
         m_ef = 0; m_rec = 1; m_shr = 0;
      end else begin
         vq  = vd[m_ch] && (!m_on || m_rec);
         lq  = vl[m_ch] && (!m_on || m_rec);
         aup = (m_pol == 2'd1) || (m_pol == 2'd2);
         adn = (m_pol == 2'd1) || (m_pol == 2'd3);
         if (!m_on) n_on = aup ? vq : hu;
         else       n_on = !(adn ? lq : hd);
         n_irq = ak ? 1'b0 : (vq ? 1'b1 : m_irq);
         m_on = n_on; m_irq = n_irq;
         if (we && ad == 1'b0) begin
            m_pol = wd[7:6]; m_ch = wd[5:4]; m_cs = wd[3:2]; m_ef = wd[1:0];
         end else if (we) begin
            m_rec = wd[0]; m_shr = wd[1];
         end
      end
      e.on = m_on; e.irq = m_irq; e.cs = m_cs; e.ef = m_ef;
      e.sd = (m_shr && !m_on) ? m_irq : au;
      exp_q.push_back(e);
      req_q.push_back(req);
   endtask

   task automatic idle(input string req);
      step(0, 0, 0, 8'h00, 4'h0, 4'h0, 0, 0, 0, 0, req);
   endtask

   task automatic wr(input logic ad, input logic [7:0] wd, input string req);
      step(0, 1, ad, wd, 4'h0, 4'h0, 0, 0, 0, 0, req);
   endtask

   // monitor: compares one item per clock, 1 ns after the edge
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         exp_t  e;
         string rq;
         e  = exp_q.pop_front();
         rq = req_q.pop_front();
         n_vec++;
         if ({adc_power_on, irq, sdout, vad_clk_src, vad_ext_freq} !== e) begin
            n_miss++;
            $display("FAIL %s: on/irq/sdout/clk/freq actual %b %b %b %0d %0d expected %b %b %b %0d %0d",
                     rq, adc_power_on, irq, sdout, vad_clk_src, vad_ext_freq,
                     e.on, e.irq, e.sd, e.cs, e.ef);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_miss++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
         $finish;
      end
   end

   initial begin
      // R1: reset state, sdout follows audio with pin sharing off
      step(1, 0, 0, 8'h00, 4'h0, 4'h0, 0, 0, 0, 1, "R1");
      step(1, 0, 0, 8'h00, 4'h0, 4'h0, 0, 0, 0, 0, "R1");
      idle("R1");
      // R3: default select 2 watches lane 2; other lanes ignored
      step(0, 0, 0, 0, 4'b1011, 4'b1011, 0, 0, 0, 0, "R3");
      step(0, 0, 0, 0, 4'b0100, 4'h0, 0, 0, 0, 0, "R3");   // irq next
      // R4: policy 0, voice does not power up; host pulses do
      step(0, 0, 0, 0, 4'b0100, 4'h0, 0, 0, 0, 0, "R4");
      step(0, 0, 0, 0, 4'h0, 4'h0, 1, 0, 0, 1, "R4");
      step(0, 0, 0, 0, 4'h0, 4'b0100, 0, 0, 0, 0, "R4");
      step(0, 0, 0, 0, 4'h0, 4'h0, 0, 1, 0, 0, "R4");
      // R9: ack and event together, ack wins, next event re-sets
      step(0, 0, 0, 0, 4'b0100, 4'h0, 0, 0, 1, 0, "R9");
      step(0, 0, 0, 0, 4'b0100, 4'h0, 0, 0, 0, 0, "R9");
      step(0, 0, 0, 0, 4'h0, 4'h0, 0, 0, 1, 0, "R9");
      // R2, R12: policy 1, lane 0, clock code 2, freq code 3
      wr(0, 8'b01_00_10_11, "R12");
      idle("R2");
      // R5: auto both, host ignored
      step(0, 0, 0, 0, 4'h0, 4'h0, 1, 0, 0, 0, "R5");
      step(0, 0, 0, 0, 4'b0001, 4'h0, 0, 0, 0, 1, "R5");
      step(0, 0, 0, 0, 4'h0, 4'h0, 0, 1, 1, 0, "R5");
      step(0, 0, 0, 0, 4'h0, 4'b0001, 0, 0, 0, 0, "R5");
      // R10: recording-detect off (bit 0 = 0), upper bits ignored
      wr(1, 8'b1111_1100, "R2");
      step(0, 0, 0, 0, 4'b0001, 4'h0, 0, 0, 1, 0, "R10");   // off: qualifies
      step(0, 0, 0, 0, 4'b0001, 4'h0, 0, 0, 1, 1, "R10");   // on: suppressed
      step(0, 0, 0, 0, 4'h0, 4'b0001, 0, 0, 0, 0, "R10");
      wr(1, 8'b0000_0001, "R10");
      step(0, 0, 0, 0, 4'h0, 4'b0001, 0, 0, 0, 0, "R10");
      // R6: policy 2, lane 1
      wr(0, 8'b10_01_01_01, "R6");
      step(0, 0, 0, 0, 4'h0, 4'h0, 1, 0, 0, 0, "R6");
      step(0, 0, 0, 0, 4'b0010, 4'h0, 0, 0, 0, 0, "R6");
      step(0, 0, 0, 0, 4'h0, 4'b0010, 0, 0, 1, 0, "R6");
      step(0, 0, 0, 0, 4'h0, 4'h0, 0, 1, 0, 0, "R6");
      // R7: policy 3, lane 3
      wr(0, 8'b11_11_00_10, "R7");
      step(0, 0, 0, 0, 4'b1000, 4'h0, 0, 0, 0, 0, "R7");
      step(0, 0, 0, 0, 4'h0, 4'h0, 1, 0, 1, 0, "R7");
      step(0, 0, 0, 0, 4'h0, 4'h0, 0, 1, 0, 0, "R7");
      step(0, 0, 0, 0, 4'h0, 4'b1000, 0, 0, 0, 0, "R7");
      // R11: pin sharing on; off shows irq, on shows audio
      wr(1, 8'b0000_0011, "R11");
      step(0, 0, 0, 0, 4'b1000, 4'h0, 0, 0, 0, 0, "R8");
      step(0, 0, 0, 0, 4'h0, 4'h0, 0, 0, 0, 0, "R11");
      step(0, 0, 0, 0, 4'h0, 4'h0, 1, 0, 0, 0, "R11");
      step(0, 0, 0, 0, 4'h0, 4'h0, 0, 0, 0, 1, "R11");
      step(0, 0, 0, 0, 4'h0, 4'h0, 0, 0, 1, 0, "R11");
      // random stream with occasional reconfiguration
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] rv;
         rv = $urandom;
         step(0, rv[3:0] == 4'd0, rv[4], rv[12:5],
              rv[16:13] & {4{rv[17]}}, rv[21:18] & {4{rv[22]}},
              rv[23] & rv[24], rv[25] & rv[26], rv[27] & rv[28], rv[29],
              "R8 random");
      end
      step(1, 0, 0, 8'h00, 4'h0, 4'h0, 0, 0, 0, 0, "R1");
      idle("R1");
      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
   end

endmodule